// File: doc/BRIEF.md
# SPI Real-Time-Clock Register Target

This block is an SPI target that gives a host access to a bank of timekeeping registers. The host opens a frame by raising an active-high chip enable. The first byte of a frame is a command: its top bit chooses write or read, and its lower seven bits give the starting register address. Every byte after that moves data to or from the addressed register, and the pointer then steps to the next address. A whole time stamp can therefore be read or written in a single burst.

The bank holds BCD seconds, minutes and hours, a day-of-week, a date, a month and a year. It also holds two four-byte alarm sets, a control byte with a write-protect flag, a read-only status byte, a charger setting byte and a small user RAM window. A one-cycle tick input advances the seconds. The seconds carry into the minutes and the minutes into the hours, in 24-hour or 12-hour form as the hours register selects. The chip-enable, clock and data pins are brought into the system clock domain through a chain of synchronizer flops. All edge detection is done on the synchronized copies.

Top module: `rtc_spi_regfile`

## Requirements
- R1: After reset, day of week (0x03), date (0x04) and month (0x05) read 0x01, and every other register, including control and the user RAM, reads 0x00.
- R2: A frame spans the time the chip enable is high. Bits move most significant bit first. The target samples data on the rising SPI clock edge and changes its output after the falling edge, with the clock idling high. A first byte with bit 7 set starts a write frame and one with bit 7 clear starts a read frame, and a read frame changes no register.
- R3: Each data byte in a frame uses the current address and then advances it by one. The 7-bit address wraps from 0x7F to 0x00.
- R4: Registers keep only their defined bits: seconds, minutes and hours 0x7F; day of week 0x07; date 0x3F; month 0x1F; year, both alarm sets (0x07 to 0x0E) and charger byte (0x11) 0xFF; control (0x0F) 0x47.
- R5: While control bit 6 is set, writes to every address except 0x0F are dropped. Control stays writable, and writing 0x00 to it lifts the protection.
- R6: The status byte (0x10), addresses 0x12 to 0x1F and addresses above the RAM window read 0x00, and writes to them have no effect.
- R7: The user RAM occupies USER_RAM_BYTES bytes from address 0x20 and stores full bytes.
- R8: Each tick pulse advances seconds in BCD. From 0x59 the seconds go to 0x00 and minutes advance in the same way, and minutes from 0x59 go to 0x00 and carry into the hours.
- R9: With hours bit 6 clear (24-hour form, BCD in bits 5:0), the hours carry steps in BCD, and 0x23 goes to 0x00.
- R10: With hours bit 6 set (12-hour form, bit 5 = PM, BCD 1 to 12 in bits 4:0), 11 goes to 12 and toggles PM, and 12 goes to 1 with PM unchanged.
- R11: The data output is low while the chip enable is low and during the command byte and the data bytes of write frames.
- R12: A frame that ends in the middle of a byte writes nothing from that byte, and the next frame starts again with a command byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse that advances the seconds |
| spi_ce | input | 1 | Active-high frame enable from the host |
| spi_sck | input | 1 | SPI clock, idles high |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |

## Verification
The bench builds the block with SYNC_STAGES = 3 and USER_RAM_BYTES = 16. The deeper synchronizer checks that the serial timing still holds with extra input latency, and the small RAM makes its upper boundary and the empty space above it cheap to sweep. The bench covers every core register with an all-ones mask probe and every unimplemented address from 0x12 to 0x7F. It runs tick windows in both hour forms, checked against an arithmetic model of elapsed seconds. These windows cover the 23-to-00, 11-to-12 and 12-to-1 changes.

// File: rtl/rtc_spi_pkg.sv
package rtc_spi_pkg;

   localparam int unsigned ADDR_W    = 7;
   localparam int unsigned CORE_REGS = 18;
   localparam int unsigned WP_BIT    = 6;

   localparam logic [ADDR_W-1:0] A_CTRL = 7'h0F;
   localparam logic [ADDR_W-1:0] A_RAM  = 7'h20;

   localparam int unsigned I_SEC  = 0;
   localparam int unsigned I_MIN  = 1;
   localparam int unsigned I_HOUR = 2;
   localparam int unsigned I_CTRL = 15;

   // stored bit mask per core register index
   function automatic logic [7:0] reg_mask(input int unsigned idx);
      case (idx)
         0, 1, 2:  return 8'h7F;
         3:        return 8'h07;
         4:        return 8'h3F;
         5:        return 8'h1F;
         15:       return 8'h47;
         16:       return 8'h00;
         default:  return 8'hFF;
      endcase
   endfunction

   function automatic logic [7:0] reg_reset(input int unsigned idx);
      case (idx)
         3, 4, 5: return 8'h01;
         default: return 8'h00;
      endcase
   endfunction

   function automatic logic [7:0] bcd_step(input logic [7:0] v);
      if (v[3:0] == 4'h9) return {v[7:4] + 4'h1, 4'h0};
      else                return {v[7:4], v[3:0] + 4'h1};
   endfunction

   // seconds / minutes: 00..59
   function automatic logic [7:0] sexa_next(input logic [7:0] v);
      if (v == 8'h59) return 8'h00;
      else            return bcd_step(v);
   endfunction

   function automatic logic [7:0] hour_next(input logic [7:0] h);
      logic [7:0] hv;
      logic       pm;
      if (h[6]) begin
         hv = {3'b000, h[4:0]};
         pm = h[5];
         if (hv == 8'h12) begin
            hv = 8'h01;
         end else if (hv == 8'h11) begin
            hv = 8'h12;
            pm = ~pm;
         end else begin
            hv = bcd_step(hv);
         end
         return {1'b0, 1'b1, pm, hv[4:0]};
      end else begin
         if (h[5:0] == 6'h23) return 8'h00;
         hv = bcd_step({2'b00, h[5:0]});
         return {2'b00, hv[5:0]};
      end
   endfunction

endpackage

// File: rtl/rtc_sync.sv
module rtc_sync #(
   parameter int unsigned WIDTH  = 1,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);

   logic [WIDTH-1:0] stage_q [STAGES];

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("rtc_sync: STAGES must be at least 2");
      end
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[s] <= '0;
               else        stage_q[s] <= din;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[s] <= '0;
               else        stage_q[s] <= stage_q[s-1];
            end
         end
      end
   endgenerate

   assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/rtc_spi_frontend.sv
module rtc_spi_frontend
   import rtc_spi_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_s,
   input  logic              sck_s,
   input  logic              mosi_s,
   input  logic [7:0]        rd_data,
   output logic [ADDR_W-1:0] rd_addr,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [7:0]        wr_data,
   output logic              miso
);

   logic              ce_d, sck_d;
   logic [2:0]        bit_cnt;
   logic              in_data, is_wr;
   logic [ADDR_W-1:0] ptr;
   logic [6:0]        rx_sr;
   logic [7:0]        tx_sr;
   logic              ce_rise, sck_rise, sck_fall, byte_done;
   logic [7:0]        rx_byte;

   assign ce_rise   = ce_s & ~ce_d;
   assign sck_rise  = ce_s & sck_s & ~sck_d;
   assign sck_fall  = ce_s & ~sck_s & sck_d;
   assign rx_byte   = {rx_sr, mosi_s};
   assign byte_done = sck_rise && (bit_cnt == 3'd7);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ce_d    <= 1'b0;
         sck_d   <= 1'b0;
         bit_cnt <= '0;
         in_data <= 1'b0;
         is_wr   <= 1'b0;
         ptr     <= '0;
         rx_sr   <= '0;
         tx_sr   <= '0;
      end else begin
         ce_d  <= ce_s;
         sck_d <= sck_s;
         if (!ce_s || ce_rise) begin
            bit_cnt <= '0;
            in_data <= 1'b0;
            is_wr   <= 1'b0;
            tx_sr   <= '0;
         end else begin
            if (sck_rise) begin
               rx_sr   <= rx_byte[6:0];
               bit_cnt <= bit_cnt + 3'd1;
               if (bit_cnt == 3'd7) begin
                  if (!in_data) begin
                     ptr     <= rx_byte[ADDR_W-1:0];
                     is_wr   <= rx_byte[7];
                     in_data <= 1'b1;
                  end else begin
                     ptr <= ptr + 1'b1;
                  end
               end
            end
            if (sck_fall) begin
               if (bit_cnt == 3'd0 && in_data && !is_wr) tx_sr <= rd_data;
               else                                     tx_sr <= {tx_sr[6:0], 1'b0};
            end
         end
      end
   end

   assign wr_en   = byte_done && in_data && is_wr;
   assign wr_addr = ptr;
   assign wr_data = rx_byte;
   assign rd_addr = ptr;
   assign miso    = tx_sr[7];

   AST_MISO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !ce_s |=> (miso == 1'b0)); // R11
   AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (ce_s && !ce_rise && !sck_fall) |=> $stable(tx_sr)); // R2
   AST_ADDR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_done && !in_data) |=> (in_data && ptr == $past(rx_byte[ADDR_W-1:0]))); // R2
   AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_done && in_data) |=> (ptr == $past(ptr) + 7'd1)); // R3

endmodule

// File: rtl/rtc_time_regs.sv
module rtc_time_regs
   import rtc_spi_pkg::*;
#(
   parameter int unsigned USER_RAM_BYTES = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [7:0]        wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [7:0]        rd_data
);

   localparam int unsigned CIDX_W = $clog2(CORE_REGS);
   localparam logic [ADDR_W-1:0] CORE_LIM = ADDR_W'(CORE_REGS);

   logic [CORE_REGS-1:0][7:0] core_q, core_d;
   logic                      wr_ok, wr_core, sec_wrap, min_wrap;
   logic                      ram_hit;
   logic [7:0]                ram_rd;

   assign wr_ok    = wr_en && (wr_addr == A_CTRL || !core_q[I_CTRL][WP_BIT]);
   assign wr_core  = wr_ok && (wr_addr < CORE_LIM);
   assign sec_wrap = tick && (core_q[I_SEC] == 8'h59);
   assign min_wrap = sec_wrap && (core_q[I_MIN] == 8'h59);

   always_comb begin
      core_d = core_q;
      if (tick)     core_d[I_SEC]  = sexa_next(core_q[I_SEC]);
      if (sec_wrap) core_d[I_MIN]  = sexa_next(core_q[I_MIN]);
      if (min_wrap) core_d[I_HOUR] = hour_next(core_q[I_HOUR]);
      if (wr_core) begin
         for (int i = 0; i < CORE_REGS; i++) begin
            if (wr_addr[CIDX_W-1:0] == CIDX_W'(i)) core_d[i] = wr_data & reg_mask(i);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < CORE_REGS; i++) core_q[i] <= reg_reset(i);
      end else begin
         core_q <= core_d;
      end
   end

   generate
      if (USER_RAM_BYTES == 1 || USER_RAM_BYTES > 96) begin : g_bad_ram
         $error("rtc_time_regs: USER_RAM_BYTES must be 0 or 2..96");
      end
      if (USER_RAM_BYTES > 0) begin : g_ram
         localparam int unsigned RIDX_W = $clog2(USER_RAM_BYTES);
         localparam logic [ADDR_W-1:0] RAM_LEN = ADDR_W'(USER_RAM_BYTES);
         logic [USER_RAM_BYTES-1:0][7:0] ram_q;
         logic [ADDR_W-1:0] wr_off, rd_off;
         logic              wr_hit;

         assign wr_off  = wr_addr - A_RAM;
         assign rd_off  = rd_addr - A_RAM;
         assign wr_hit  = wr_ok && (wr_addr >= A_RAM) && (wr_off < RAM_LEN);
         assign ram_hit = (rd_addr >= A_RAM) && (rd_off < RAM_LEN);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ram_q <= '0;
            end else if (wr_hit) begin
               for (int j = 0; j < USER_RAM_BYTES; j++) begin
                  if (wr_off[RIDX_W-1:0] == RIDX_W'(j)) ram_q[j] <= wr_data;
               end
            end
         end

         always_comb begin
            ram_rd = 8'h00;
            for (int j = 0; j < USER_RAM_BYTES; j++) begin
               if (ram_hit && rd_off[RIDX_W-1:0] == RIDX_W'(j)) ram_rd = ram_q[j];
            end
         end
      end else begin : g_no_ram
         assign ram_hit = 1'b0;
         assign ram_rd  = 8'h00;
      end
   endgenerate

   always_comb begin
      rd_data = 8'h00;
      if (rd_addr < CORE_LIM) begin
         for (int i = 0; i < CORE_REGS; i++) begin
            if (rd_addr[CIDX_W-1:0] == CIDX_W'(i)) rd_data = core_q[i];
         end
      end else if (ram_hit) begin
         rd_data = ram_rd;
      end
   end

   AST_WP_HOLDS_YEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && core_q[I_CTRL][WP_BIT] && wr_addr == 7'h06) |=> $stable(core_q[6])); // R5
   AST_CTRL_WRITABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == A_CTRL) |=> (core_q[I_CTRL] == ($past(wr_data) & 8'h47))); // R5
   AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && core_q[I_SEC] == 8'h59 && !wr_en) |=> (core_q[I_SEC] == 8'h00)); // R8
   AST_HOUR24_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && core_q[I_SEC] == 8'h59 && core_q[I_MIN] == 8'h59 && core_q[I_HOUR] == 8'h23 && !wr_en)
      |=> (core_q[I_HOUR] == 8'h00)); // R9
   AST_HOUR12_NOON: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && core_q[I_SEC] == 8'h59 && core_q[I_MIN] == 8'h59 && core_q[I_HOUR] == 8'h51 && !wr_en)
      |=> (core_q[I_HOUR] == 8'h72)); // R10

endmodule

// File: rtl/rtc_spi_regfile.sv
module rtc_spi_regfile
   import rtc_spi_pkg::*;
#(
   parameter int unsigned SYNC_STAGES    = 2,
   parameter int unsigned USER_RAM_BYTES = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic spi_ce,
   input  logic spi_sck,
   input  logic spi_mosi,
   output logic spi_miso
);

   localparam int unsigned PIN_W = 3;

   logic [PIN_W-1:0]  pins_s;
   logic              wr_en;
   logic [ADDR_W-1:0] wr_addr, rd_addr;
   logic [7:0]        wr_data, rd_data;

   rtc_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES)) sync_i (
      .clk  (clk),
      .rst_n(rst_n),
      .din  ({spi_ce, spi_sck, spi_mosi}),
      .dout (pins_s)
   );

   rtc_spi_frontend front_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .ce_s   (pins_s[2]),
      .sck_s  (pins_s[1]),
      .mosi_s (pins_s[0]),
      .rd_data(rd_data),
      .rd_addr(rd_addr),
      .wr_en  (wr_en),
      .wr_addr(wr_addr),
      .wr_data(wr_data),
      .miso   (spi_miso)
   );

   rtc_time_regs #(.USER_RAM_BYTES(USER_RAM_BYTES)) regs_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick),
      .wr_en  (wr_en),
      .wr_addr(wr_addr),
      .wr_data(wr_data),
      .rd_addr(rd_addr),
      .rd_data(rd_data)
   );

endmodule

// File: tb/rtc_spi_regfile_tb_top.sv
module rtc_spi_regfile_tb_top;

   localparam int RAM_N = 16;
   localparam int HALF  = 8;

   logic clk = 1'b0;
   logic rst_n, tick, spi_ce, spi_sck, spi_mosi;
   logic spi_miso;
   int   n_cmp = 0;
   int   n_bad = 0;
   bit   done  = 1'b0;
   logic [7:0] bq [0:31];

   always #10 clk = ~clk;

   rtc_spi_regfile #(.SYNC_STAGES(3), .USER_RAM_BYTES(RAM_N)) dut_i (
      .clk(clk), .rst_n(rst_n), .tick(tick), .spi_ce(spi_ce),
      .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
      for (int b = 7; b >= 0; b--) begin
         spi_sck  = 1'b0;
         spi_mosi = tx[b];
         repeat (HALF) @(negedge clk);
         rx[b]   = spi_miso;
         spi_sck = 1'b1;
         repeat (HALF) @(negedge clk);
      end
   endtask

   task automatic f_open();
      spi_ce = 1'b1;
      repeat (HALF) @(negedge clk);
   endtask

   task automatic f_close();
      repeat (HALF) @(negedge clk);
      spi_ce = 1'b0;
      repeat (2 * HALF) @(negedge clk);
   endtask

   task automatic wr_burst(input logic [6:0] a, input int n);
      logic [7:0] r;
      f_open();
      spi_byte({1'b1, a}, r);
      for (int i = 0; i < n; i++) spi_byte(bq[i], r);
      f_close();
   endtask

   task automatic rd_burst(input logic [6:0] a, input int n);
      logic [7:0] r;
      f_open();
      spi_byte({1'b0, a}, r);
      for (int i = 0; i < n; i++) begin spi_byte(8'hFF, r); bq[i] = r; end
      f_close();
   endtask

   task automatic wr1(input logic [6:0] a, input logic [7:0] v);
      bq[0] = v; wr_burst(a, 1);
   endtask

   task automatic rd1(input logic [6:0] a, output logic [7:0] v);
      rd_burst(a, 1); v = bq[0];
   endtask

   function automatic int b2i(input logic [7:0] x);
      return int'(x[7:4]) * 10 + int'(x[3:0]);
   endfunction

   function automatic logic [7:0] i2b(input int x);
      return 8'(((x / 10) << 4) | (x % 10));
   endfunction

   function automatic int hr24(input logic [7:0] r);
      if (r[6]) return (b2i({3'b0, r[4:0]}) % 12) + (r[5] ? 12 : 0);
      return b2i({2'b0, r[5:0]});
   endfunction

   function automatic logic [7:0] hr_enc(input int h, input bit twelve);
      int h12;
      if (!twelve) return i2b(h);
      h12 = (h % 12 == 0) ? 12 : h % 12;
      return 8'h40 | ((h >= 12) ? 8'h20 : 8'h00) | i2b(h12);
   endfunction

   // set time, pulse n ticks, compare with elapsed-seconds model (R8/R9/R10)
   task automatic tick_run(input string req, input int h, input int m, input int s,
                           input bit twelve, input int n);
      int t;
      bq[0] = i2b(s); bq[1] = i2b(m); bq[2] = hr_enc(h, twelve);
      wr_burst(7'h00, 3);
      for (int i = 0; i < n; i++) begin
         tick = 1'b1; @(negedge clk);
         tick = 1'b0; @(negedge clk);
      end
      t = (h * 3600 + m * 60 + s + n) % 86400;
      rd_burst(7'h00, 3);
      chk(req, bq[0], i2b(t % 60));
      chk(req, bq[1], i2b((t / 60) % 60));
      chk(req, bq[2], hr_enc(t / 3600, twelve));
   endtask

   initial begin
      logic [7:0] v;
      logic [7:0] r;
      rst_n = 1'b0; tick = 1'b0; spi_ce = 1'b0; spi_sck = 1'b1; spi_mosi = 1'b0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      // R1 reset values, read as one burst (R3)
      chk("R11 idle", {7'b0, spi_miso}, 8'h00);
      rd_burst(7'h00, 18);
      for (int i = 0; i < 18; i++) chk("R1 core reset", bq[i], (i >= 3 && i <= 5) ? 8'h01 : 8'h00);
      rd_burst(7'h20, RAM_N);
      for (int i = 0; i < RAM_N; i++) chk("R1 ram reset", bq[i], 8'h00);

      // R4 masks: all-ones into each core register
      for (int i = 0; i < 18; i++) begin
         logic [7:0] m;
         wr1(7'(i), 8'hFF);
         rd1(7'(i), v);
         case (i)
            0, 1, 2: m = 8'h7F;
            3:       m = 8'h07;
            4:       m = 8'h3F;
            5:       m = 8'h1F;
            15:      m = 8'h47;
            16:      m = 8'h00;
            default: m = 8'hFF;
         endcase
         chk((i == 16) ? "R6 status" : "R4 mask", v, m);
         if (i == 15) wr1(7'h0F, 8'h00);
      end

      // R3 burst write of the time block, then read back
      for (int i = 0; i < 7; i++) bq[i] = 8'(8'h11 * (i + 1)) & 8'h17;
      wr_burst(7'h00, 7);
      rd_burst(7'h00, 7);
      for (int i = 0; i < 7; i++) chk("R3 burst", bq[i], 8'(8'h11 * (i + 1)) & 8'h17);

      // R2 read frame with ones on the data line leaves the register alone
      rd1(7'h06, v);
      chk("R2 read no write", v, 8'h17);

      // R6 unimplemented addresses
      for (int a = 8'h12; a < 8'h80; a++) begin
         if (a >= 8'h20 && a < 8'h20 + RAM_N) continue;
         wr1(7'(a), 8'hA5);
         rd1(7'(a), v);
         chk("R6 unimpl", v, 8'h00);
      end

      // R7 user RAM
      for (int i = 0; i < RAM_N; i++) bq[i] = 8'(8'h3C ^ (i * 17));
      wr_burst(7'h20, RAM_N);
      rd_burst(7'h20, RAM_N);
      for (int i = 0; i < RAM_N; i++) chk("R7 ram", bq[i], 8'(8'h3C ^ (i * 17)));

      // R3 address wrap 0x7F -> 0x00
      bq[0] = 8'hAA; bq[1] = 8'h33;
      wr_burst(7'h7F, 2);
      rd1(7'h00, v);
      chk("R3 wrap", v, 8'h33);

      // R11 write-frame data byte returns zero on the data output
      f_open();
      spi_byte(8'h91, r);
      chk("R11 cmd byte", r, 8'h00);
      spi_byte(8'h5A, r);
      chk("R11 write data", r, 8'h00);
      f_close();

      // R5 write protect
      wr1(7'h06, 8'h42);
      wr1(7'h0F, 8'h40);
      wr1(7'h06, 8'h99);
      wr1(7'h21, 8'h00);
      wr1(7'h08, 8'h77);
      rd1(7'h06, v); chk("R5 year held", v, 8'h42);
      rd1(7'h21, v); chk("R5 ram held", v, 8'(8'h3C ^ 17));
      rd1(7'h08, v); chk("R5 alarm held", v, 8'hFF);
      rd1(7'h0F, v); chk("R5 ctrl", v, 8'h40);
      wr1(7'h0F, 8'h00);
      wr1(7'h06, 8'h99);
      rd1(7'h06, v); chk("R5 unprotected", v, 8'h99);

      // R12 aborted frame
      f_open();
      spi_byte(8'h86, r);
      for (int b = 7; b >= 4; b--) begin
         spi_sck = 1'b0; spi_mosi = b[0];
         repeat (HALF) @(negedge clk);
         spi_sck = 1'b1;
         repeat (HALF) @(negedge clk);
      end
      spi_ce = 1'b0;
      repeat (2 * HALF) @(negedge clk);
      rd1(7'h06, v);
      chk("R12 abort", v, 8'h99);

      // R8 R9 R10 tick windows
      tick_run("R8 R9 24h wrap", 23, 59, 50, 1'b0, 25);
      tick_run("R8 24h sweep",    9, 58, 40, 1'b0, 1500);
      tick_run("R10 11to12",     11, 59, 58, 1'b1, 3);
      tick_run("R10 12to1",      12, 59, 55, 1'b1, 10);
      tick_run("R10 midnight",   23, 59, 59, 1'b1, 1);
      tick_run("R10 12h sweep",   0, 59, 30, 1'b1, 3700);

      chk("R11 idle end", {7'b0, spi_miso}, 8'h00);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule